// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block folds interrupt activity from three groups of secondary sources into one level output. The groups are a 32-bit USB-core vector, a DMA completion vector and a GPIO vector. Each group holds a pending vector and a mask vector. Software sets pending bits through a set register and removes them through a clear register. A mask bit of 1 hides the pending bit at the same position.

Each group's unmasked activity is reduced to summary bits. These bits sit at fixed positions of a 32-bit top-level source register. The USB-core vector gives two summaries: its low half is the transmit summary and its high half is the receive summary. The top-level register has its own set, clear and mask registers. Outside units can also set any of its non-summary bits with single-cycle pulses.

A configuration register picks the active level of the output. An enable input gates the output. The output is registered.

Top module: `irq_fold`

## Requirements
- R1: After reset, every pending vector, the top-level source register and the configuration register read zero, and every mask (the three group masks and the top-level mask) reads all ones.
- R2: A write to a set address ORs the written data into that register's pending bits. The other bits stay unchanged.
- R3: A write to a clear address removes every pending bit where the written data has a 1 (pending AND NOT data).
- R4: Top-level bit 9 is 1 exactly when some bit in 15:0 of the USB-core vector is pending and unmasked. Top-level bit 8 is 1 exactly when some bit in 31:16 of that vector is pending and unmasked.
- R5: Top-level bit 24 is 1 exactly when some DMA bit is pending and unmasked.
- R6: Top-level bit 25 is 1 exactly when some GPIO bit is pending and unmasked.
- R7: When bit 17 of the configuration register is 1, the output is high while any top-level bit is pending and unmasked. When bit 17 is 0, the output is high only while no such bit exists.
- R8: The output is ANDed with `irq_en_i`, and that input is sampled at the clock edge. A low enable forces the output low one clock later.
- R9: Address map, in word units:
  - 0–3: USB-core group; 4–7: DMA group; 8–11: GPIO group; 12–15: top-level register.
  - Within each group of four, offsets 0, 1 and 2 (source, set, clear) all read the pending vector. Offset 3 reads and writes the mask.
  - Address 16 is the configuration register.
- R10: A 1 on `ext_set_i` sets the matching non-summary top-level bit at that clock edge. This holds even when a top-level clear of the same bit is written in the same cycle.
- R11: Software set and clear writes and `ext_set_i` pulses have no effect on summary bits 8, 9, 24 and 25.
- R12: The registered state and `irq_o` update at the clock edge that takes the write. Before that edge, `irq_o` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en_i | input | 1 | Output enable qualifier |
| ext_set_i | input | 32 | Single-cycle set pulses for top-level bits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| irq_o | output | 1 | Aggregated interrupt level |

## Verification
The summary assertions assume the group and top-level registers only change through the decoded write strobes and the pulse input. The bench therefore drives each write for exactly one clock, at the falling edge, and never drives two strobes at once except in the planned set-beats-clear case. The output assertion relies on `irq_en_i` being steady across each sampling edge. The bench changes the enable only on falling edges, and it checks the output only after the first edge that follows reset release.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;

   typedef enum logic [1:0] {
      SLOT_SRC  = 2'd0,
      SLOT_SET  = 2'd1,
      SLOT_CLR  = 2'd2,
      SLOT_MASK = 2'd3
   } slot_e;

   typedef enum logic [1:0] {
      GRP_CORE = 2'd0,
      GRP_DMA  = 2'd1,
      GRP_GPIO = 2'd2,
      GRP_TOP  = 2'd3
   } grp_e;

   localparam int NUM_GRP  = 4;
   localparam int CFG_WORD = 16;

endpackage

// File: rtl/irq_fold_group.sv
module irq_fold_group #(
   parameter int          W        = 32,
   parameter int          N_SUM    = 1,
   parameter logic [W-1:0] MASK_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic             mask_we,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     pend_q,
   output logic [W-1:0]     mask_q,
   output logic [N_SUM-1:0] sum_nxt
);
   localparam int SLICE = W / N_SUM;

   if (N_SUM < 1 || (W % N_SUM) != 0) begin : g_bad_split
      $error("irq_fold_group: W must split evenly into N_SUM slices");
   end

   logic [W-1:0] pend_nxt, mask_nxt;

   always_comb begin
      pend_nxt = pend_q;
      if (set_we) pend_nxt = pend_nxt | wdata;
      if (clr_we) pend_nxt = pend_nxt & ~wdata;
      mask_nxt = mask_we ? wdata : mask_q;
   end

   for (genvar i = 0; i < N_SUM; i++) begin : g_sum
      assign sum_nxt[i] = |(pend_nxt[i*SLICE +: SLICE] & ~mask_nxt[i*SLICE +: SLICE]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= MASK_RST;
      end else begin
         pend_q <= pend_nxt;
         mask_q <= mask_nxt;
      end
   end

   p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> pend_q == ($past(pend_q) | $past(wdata)));

   p_clr_andn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> pend_q == ($past(pend_q) & ~$past(wdata)));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(pend_q));

endmodule

// File: rtl/irq_fold_source.sv
module irq_fold_source #(
   parameter int           W       = 32,
   parameter logic [W-1:0] HW_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic         mask_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] ext_set,
   input  logic [W-1:0] hw_val,
   output logic [W-1:0] src_q,
   output logic [W-1:0] mask_q,
   output logic [W-1:0] src_nxt,
   output logic [W-1:0] mask_nxt
);
   logic [W-1:0] sw_nxt;

   always_comb begin
      sw_nxt = src_q;
      if (set_we) sw_nxt = sw_nxt | wdata;
      if (clr_we) sw_nxt = sw_nxt & ~wdata;
      sw_nxt   = sw_nxt | ext_set;
      src_nxt  = (sw_nxt & ~HW_MASK) | (hw_val & HW_MASK);
      mask_nxt = mask_we ? wdata : mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         mask_q <= '1;
      end else begin
         src_q  <= src_nxt;
         mask_q <= mask_nxt;
      end
   end

   p_ext_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      |ext_set |=> ((src_q & $past(ext_set & ~HW_MASK)) == $past(ext_set & ~HW_MASK)));

endmodule

// File: rtl/irq_fold_drive.sv
module irq_fold_drive #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         pol_high,
   input  logic [W-1:0] src_nxt,
   input  logic [W-1:0] mask_nxt,
   output logic         irq_q
);
   logic any_live, irq_d;

   always_comb begin
      any_live = |(src_nxt & ~mask_nxt);
      irq_d    = en & (pol_high ? any_live : ~any_live);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_d;
   end

   p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !irq_q);

endmodule

// File: rtl/irq_fold.sv
module irq_fold
   import irq_fold_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int CORE_W   = 32,
   parameter int DMA_W    = 32,
   parameter int GPIO_W   = 32,
   parameter int TX_BIT   = 9,
   parameter int RX_BIT   = 8,
   parameter int DMA_BIT  = 24,
   parameter int GPIO_BIT = 25,
   parameter int POL_BIT  = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_en_i,
   input  logic [DATA_W-1:0] ext_set_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);
   localparam int HALF = CORE_W / 2;
   localparam logic [DATA_W-1:0] HW_MASK = (DATA_W'(1) << TX_BIT) | (DATA_W'(1) << RX_BIT)
                                         | (DATA_W'(1) << DMA_BIT) | (DATA_W'(1) << GPIO_BIT);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("irq_fold: ADDR_W must be at least 5");
   end
   if (CORE_W > DATA_W || DMA_W > DATA_W || GPIO_W > DATA_W || (CORE_W % 2) != 0) begin : g_bad_grp
      $error("irq_fold: group widths must be even-split and fit DATA_W");
   end
   if (TX_BIT >= DATA_W || RX_BIT >= DATA_W || DMA_BIT >= DATA_W || GPIO_BIT >= DATA_W
       || POL_BIT >= DATA_W || $countones(HW_MASK) != 4) begin : g_bad_bits
      $error("irq_fold: summary bits must be distinct and inside DATA_W");
   end

   // address decode
   logic             in_grp, is_cfg;
   grp_e             grp;
   slot_e            slot;
   logic [NUM_GRP-1:0] set_we, clr_we, mask_we;

   always_comb begin
      in_grp = (reg_addr_i >> 4) == '0;
      is_cfg = reg_addr_i == ADDR_W'(CFG_WORD);
      grp    = grp_e'(reg_addr_i[3:2]);
      slot   = slot_e'(reg_addr_i[1:0]);
      for (int g = 0; g < NUM_GRP; g++) begin
         set_we[g]  = reg_we_i && in_grp && (grp == grp_e'(g)) && (slot == SLOT_SET);
         clr_we[g]  = reg_we_i && in_grp && (grp == grp_e'(g)) && (slot == SLOT_CLR);
         mask_we[g] = reg_we_i && in_grp && (grp == grp_e'(g)) && (slot == SLOT_MASK);
      end
   end

   // secondary groups
   logic [CORE_W-1:0] core_pend, core_mask;
   logic [DMA_W-1:0]  dma_pend,  dma_mask;
   logic [GPIO_W-1:0] gpio_pend, gpio_mask;
   logic [1:0]        core_sum;
   logic [0:0]        dma_sum, gpio_sum;

   irq_fold_group #(.W(CORE_W), .N_SUM(2), .MASK_RST('1)) u_core (
      .clk(clk), .rst_n(rst_n),
      .set_we(set_we[GRP_CORE]), .clr_we(clr_we[GRP_CORE]), .mask_we(mask_we[GRP_CORE]),
      .wdata(reg_wdata_i[CORE_W-1:0]),
      .pend_q(core_pend), .mask_q(core_mask), .sum_nxt(core_sum));

   irq_fold_group #(.W(DMA_W), .N_SUM(1), .MASK_RST('1)) u_dma (
      .clk(clk), .rst_n(rst_n),
      .set_we(set_we[GRP_DMA]), .clr_we(clr_we[GRP_DMA]), .mask_we(mask_we[GRP_DMA]),
      .wdata(reg_wdata_i[DMA_W-1:0]),
      .pend_q(dma_pend), .mask_q(dma_mask), .sum_nxt(dma_sum));

   irq_fold_group #(.W(GPIO_W), .N_SUM(1), .MASK_RST('1)) u_gpio (
      .clk(clk), .rst_n(rst_n),
      .set_we(set_we[GRP_GPIO]), .clr_we(clr_we[GRP_GPIO]), .mask_we(mask_we[GRP_GPIO]),
      .wdata(reg_wdata_i[GPIO_W-1:0]),
      .pend_q(gpio_pend), .mask_q(gpio_mask), .sum_nxt(gpio_sum));

   // top-level source register
   logic [DATA_W-1:0] hw_val, top_q, tmask_q, top_nxt, tmask_nxt;

   always_comb begin
      hw_val           = '0;
      hw_val[TX_BIT]   = core_sum[0];
      hw_val[RX_BIT]   = core_sum[1];
      hw_val[DMA_BIT]  = dma_sum[0];
      hw_val[GPIO_BIT] = gpio_sum[0];
   end

   irq_fold_source #(.W(DATA_W), .HW_MASK(HW_MASK)) u_top (
      .clk(clk), .rst_n(rst_n),
      .set_we(set_we[GRP_TOP]), .clr_we(clr_we[GRP_TOP]), .mask_we(mask_we[GRP_TOP]),
      .wdata(reg_wdata_i), .ext_set(ext_set_i), .hw_val(hw_val),
      .src_q(top_q), .mask_q(tmask_q), .src_nxt(top_nxt), .mask_nxt(tmask_nxt));

   // configuration
   logic [DATA_W-1:0] cfg_q, cfg_nxt;

   always_comb cfg_nxt = (reg_we_i && is_cfg) ? reg_wdata_i : cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_nxt;
   end

   irq_fold_drive #(.W(DATA_W)) u_drive (
      .clk(clk), .rst_n(rst_n), .en(irq_en_i), .pol_high(cfg_nxt[POL_BIT]),
      .src_nxt(top_nxt), .mask_nxt(tmask_nxt), .irq_q(irq_o));

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      if (is_cfg) begin
         reg_rdata_o = cfg_q;
      end else if (in_grp) begin
         unique case (grp)
            GRP_CORE: reg_rdata_o[CORE_W-1:0] = (slot == SLOT_MASK) ? core_mask : core_pend;
            GRP_DMA:  reg_rdata_o[DMA_W-1:0]  = (slot == SLOT_MASK) ? dma_mask  : dma_pend;
            GRP_GPIO: reg_rdata_o[GPIO_W-1:0] = (slot == SLOT_MASK) ? gpio_mask : gpio_pend;
            default:  reg_rdata_o = (slot == SLOT_MASK) ? tmask_q : top_q;
         endcase
      end
   end

   // checks across the pieces
   logic primed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed_q <= 1'b0;
      else        primed_q <= 1'b1;
   end

   p_tx_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
      top_q[TX_BIT] == |(core_pend[HALF-1:0] & ~core_mask[HALF-1:0]));

   p_rx_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
      top_q[RX_BIT] == |(core_pend[CORE_W-1:HALF] & ~core_mask[CORE_W-1:HALF]));

   p_dma_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
      top_q[DMA_BIT] == |(dma_pend & ~dma_mask));

   p_gpio_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
      top_q[GPIO_BIT] == |(gpio_pend & ~gpio_mask));

   p_level_r7: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
      irq_o == ($past(irq_en_i) && (cfg_q[POL_BIT] ? (|(top_q & ~tmask_q))
                                                   : !(|(top_q & ~tmask_q)))));

endmodule

// File: tb/irq_fold_bench.sv
module irq_fold_bench;
   localparam int NV = 22;
   localparam int WD_CYC = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_en = 1'b1;
   logic [31:0] ext_set = '0;
   logic        we = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_fold u_irq_fold (
      .clk(clk), .rst_n(rst_n), .irq_en_i(irq_en), .ext_set_i(ext_set),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq));

   // {write addr, write data, expected irq, expected top source}
   localparam logic [69:0] VECS [NV] = '{
      {5'd16, 32'h0002_0000, 1'b0, 32'h0000_0000}, // R7 polarity high
      {5'd15, 32'h0000_0000, 1'b0, 32'h0000_0000}, // unmask top
      {5'd1,  32'h0000_0001, 1'b0, 32'h0000_0000}, // R2 masked core bit
      {5'd3,  32'h0000_0000, 1'b1, 32'h0000_0200}, // R4 TX
      {5'd1,  32'h0001_0000, 1'b1, 32'h0000_0300}, // R4 RX
      {5'd2,  32'h0000_0001, 1'b1, 32'h0000_0100}, // R3
      {5'd2,  32'h0001_0000, 1'b0, 32'h0000_0000}, // R3 R4
      {5'd5,  32'h0000_0080, 1'b0, 32'h0000_0000}, // R5 masked
      {5'd7,  32'hFFFF_FF7F, 1'b1, 32'h0100_0000}, // R5
      {5'd15, 32'h0100_0000, 1'b0, 32'h0100_0000}, // R7 top mask
      {5'd15, 32'h0000_0000, 1'b1, 32'h0100_0000}, // R7
      {5'd6,  32'h0000_0080, 1'b0, 32'h0000_0000}, // R5 clear
      {5'd9,  32'h0000_0004, 1'b0, 32'h0000_0000}, // R6 masked
      {5'd11, 32'h0000_0000, 1'b1, 32'h0200_0000}, // R6
      {5'd10, 32'h0000_0004, 1'b0, 32'h0000_0000}, // R6 clear
      {5'd13, 32'h0000_0001, 1'b1, 32'h0000_0001}, // R2 top set
      {5'd13, 32'h0000_0200, 1'b1, 32'h0000_0001}, // R11
      {5'd14, 32'h0000_0001, 1'b0, 32'h0000_0000}, // R3 top clear
      {5'd16, 32'h0000_0000, 1'b1, 32'h0000_0000}, // R7 polarity low
      {5'd13, 32'h8000_0000, 1'b0, 32'h8000_0000}, // R7
      {5'd14, 32'h8000_0000, 1'b1, 32'h0000_0000}, // R7
      {5'd16, 32'h0002_0000, 1'b0, 32'h0000_0000}  // R7
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      check("R1 irq after reset (low polarity, nothing pending)", {31'd0, irq}, 32'd1);
      rd(5'd12, v); check("R1 top source", v, 32'h0);
      rd(5'd15, v); check("R1 top mask", v, 32'hFFFF_FFFF);
      rd(5'd3, v);  check("R1 core mask", v, 32'hFFFF_FFFF);
      rd(5'd7, v);  check("R1 dma mask", v, 32'hFFFF_FFFF);
      rd(5'd11, v); check("R1 gpio mask", v, 32'hFFFF_FFFF);
      rd(5'd0, v);  check("R1 core pending", v, 32'h0);
      rd(5'd16, v); check("R1 config", v, 32'h0);

      for (int i = 0; i < NV; i++) begin
         wr(VECS[i][69:65], VECS[i][64:33]);
         check($sformatf("R12 vector %0d irq", i), {31'd0, irq}, {31'd0, VECS[i][32]});
         rd(5'd12, v);
         check($sformatf("R4 vector %0d top source", i), v, VECS[i][31:0]);
      end

      // R9 readback of all three aliases and the mask
      wr(5'd1, 32'h0000_0005);
      rd(5'd0, v); check("R9 source alias", v, 32'h5);
      rd(5'd1, v); check("R9 set alias", v, 32'h5);
      rd(5'd2, v); check("R9 clear alias", v, 32'h5);
      rd(5'd3, v); check("R9 mask", v, 32'h0);
      wr(5'd3, 32'h0000_1234);
      rd(5'd3, v); check("R9 mask after write", v, 32'h1234);
      rd(5'd12, v); check("R4 bit0 still unmasked", v, 32'h200);
      // R11 software clear of a summary bit is ignored
      wr(5'd14, 32'h0000_0200);
      rd(5'd12, v); check("R11 summary survives clear", v, 32'h200);
      wr(5'd2, 32'h0000_0005);
      wr(5'd3, 32'h0000_0000);
      rd(5'd12, v); check("R4 cleared", v, 32'h0);

      // R2/R3 partial set and clear
      wr(5'd5, 32'h0000_F0F0);
      wr(5'd6, 32'h0000_0FF0);
      rd(5'd4, v); check("R3 partial clear", v, 32'h0000_F000);
      wr(5'd6, 32'hFFFF_FFFF);

      // R12 output holds until the write edge
      @(negedge clk);
      we = 1'b1; addr = 5'd13; wdata = 32'h0000_0002;
      #1 check("R12 irq before edge", {31'd0, irq}, 32'd0);
      @(negedge clk);
      we = 1'b0;
      check("R12 irq after edge", {31'd0, irq}, 32'd1);

      // R8 enable gate
      @(negedge clk); irq_en = 1'b0;
      @(negedge clk); check("R8 enable low", {31'd0, irq}, 32'd0);
      irq_en = 1'b1;
      @(negedge clk); check("R8 enable back", {31'd0, irq}, 32'd1);
      wr(5'd14, 32'h0000_0002);

      // R10 external pulse sets a top bit
      @(negedge clk); ext_set = 32'h0000_0008;
      @(negedge clk); ext_set = '0;
      rd(5'd12, v); check("R10 pulse sets bit", v, 32'h8);
      // R10 pulse wins over simultaneous clear
      @(negedge clk);
      ext_set = 32'h0000_0008; we = 1'b1; addr = 5'd14; wdata = 32'h0000_0008;
      @(negedge clk);
      ext_set = '0; we = 1'b0;
      rd(5'd12, v); check("R10 set beats clear", v, 32'h8);
      wr(5'd14, 32'h0000_0008);
      rd(5'd12, v); check("R3 clear alone", v, 32'h0);
      // R11 pulse at a summary position is ignored
      @(negedge clk); ext_set = 32'h0000_0200;
      @(negedge clk); ext_set = '0;
      rd(5'd12, v); check("R11 pulse on summary bit", v, 32'h0);
      check("R11 irq stays low", {31'd0, irq}, 32'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R12 actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule